// File: doc/BRIEF.md
# Lane Power-State Sequencer

This block sequences one serial data lane and its companion clock lane through low-power idle, high-speed transmit and ultra-low-power states. Each transition phase is timed by its own 8-bit count, given in byte-clock cycles. The counts arrive packed four to a 32-bit timing word, with one set for the data lane and one for the clock lane. Per-lane control bits ask for high-speed transmit, ask for ultra-low-power, or give the wake-up pulse. The block reports an encoded line state for each lane and tells the packet source when the data lane can accept bytes.

The clock lane has to be running in high-speed mode before the data lane starts its entry. The clock lane keeps running for its post count after the data lane has finished its trail. To leave ultra-low-power, the enable is cleared first and the wake-up bit is then pulsed high and low.

Top module: `lane_pwr_seq`

## Requirements
- R1: Line state codes are LP-11=0, LP-01=1, LP-00=2, HS-0=3, HS active=4. While reset is held, and after it, both lanes show LP-11 and ready is low.
- R2: A data entry shows LP-01 for the LP count, then LP-00 for the prepare count, then HS-0 for the zero count, then HS active with ready high.
- R3: A data lane asking for high-speed stays in LP-11 until the clock lane has shown HS active for one cycle. Its LP-01 starts in the cycle after that.
- R4: A clock entry shows LP-01 for the LP count (shared with the data lane), then LP-00 for the clock-prepare count, then HS-0 for the clock-zero count, then HS active.
- R5: When the data transmit enable drops, ready falls and the lane shows HS-0 for the trail count. It then shows LP-11 for the exit count, and a transmit request during that hold is ignored. After the hold the lane spends one idle cycle, then starts a new entry.
- R6: The clock lane stays in HS active while the data lane is mid-sequence or requesting. Once both are clear it stays in HS active for the clock-post count, then shows HS-0 for the clock-trail count and LP-11 for the clock-exit count.
- R7: A count of zero lasts exactly one cycle.
- R8: Field positions. Data word: LP [7:0], prepare [15:8], zero [23:16], trail [31:24]. Turnaround word: exit [31:24]; its low three bytes are unused. Clock word A: zero [23:16], trail [31:24]. Clock word B: prepare [7:0], post [15:8], exit [23:16].
- R9: Control bits per lane: bit 0 high-speed enable, bit 1 ultra-low-power enable, bit 2 wake-up. When idle with bit 1 set and bit 0 clear, the lane shows LP-00. A high-speed request does not move it out of that state.
- R10: A wake-up pulse given while bit 1 is still set has no effect. Once bit 1 is clear, wake-up high and then low sends the lane to LP-11 for its exit count, and then to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tw_data | input | 32 | Data-lane entry/trail counts |
| tw_turn | input | 32 | Turnaround counts and data exit count |
| tw_clk_a | input | 32 | Clock-lane zero and trail counts |
| tw_clk_b | input | 32 | Clock-lane prepare, post and exit counts |
| dl_ctrl | input | 3 | Data-lane control bits |
| cl_ctrl | input | 3 | Clock-lane control bits |
| dl_line | output | 3 | Data-lane line state code |
| cl_line | output | 3 | Clock-lane line state code |
| dl_ready | output | 1 | Data lane in HS active, ready for bytes |

## Verification
The hardest case to reach is the hand-over between the lanes at shutdown. The clock lane must hold HS active through the whole data trail and only then begin its post count. This happens only when both enables drop in the same cycle while the data lane is active. The bench drives exactly that, once with distinct non-zero counts and once with all counts zero, so the one-cycle gap between the end of the data trail and the start of the clock post is visible. A wake-up pulse given while ultra-low-power is still enabled is followed by a quiet period, so that a design which wrongly accepted the pulse would leave LP-00.

// File: rtl/lane_seq_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the lane power-state sequencer.
// Assumes 8-bit count fields packed four to a timing word.
package lane_seq_pkg;
    localparam int FLD_W = 8;
    localparam int CB_HS = 0;
    localparam int CB_ULP = 1;
    localparam int CB_WAKE = 2;

    typedef enum logic [2:0] {
        LN_LP11  = 3'd0,
        LN_LP01  = 3'd1,
        LN_LP00  = 3'd2,
        LN_HS0   = 3'd3,
        LN_HSACT = 3'd4
    } line_t;
endpackage

// File: rtl/lane_phase_timer.sv
`timescale 1ns/1ps
// Down-counter for one transition phase. Loaded on phase entry, it
// reports done in the last cycle of the phase; a length of 0 or 1 both
// give a one-cycle phase. Assumes load and done are used by one FSM.
module lane_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lane_seq_data.sv
`timescale 1ns/1ps
// Data-lane power-state FSM. Walks LP-01 / LP-00 / HS-0 before HS
// active, trails and holds LP-11 on exit, and handles ultra-low-power
// with a wake-up pulse. Assumes clk_hs reports the clock lane in HS.
module lane_seq_data
    import lane_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_en,
    input  logic             ulp_en,
    input  logic             wake,
    input  logic             clk_hs,
    input  logic [CNT_W-1:0] len_lpx,
    input  logic [CNT_W-1:0] len_prep,
    input  logic [CNT_W-1:0] len_zero,
    input  logic [CNT_W-1:0] len_trail,
    input  logic [CNT_W-1:0] len_exit,
    output line_t            line,
    output logic             ready,
    output logic             busy
);
    typedef enum logic [3:0] {
        D_IDLE, D_LPX, D_PREP, D_ZERO, D_ACT, D_TRAIL, D_EXIT, D_ULPS, D_WAKE
    } dstate_t;

    dstate_t          st, st_nxt;
    logic             tm_load;
    logic [CNT_W-1:0] tm_len;
    logic             tm_done;

    lane_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tm_load),
        .len  (tm_len),
        .done (tm_done)
    );

    // Next state and phase-timer load for the data lane.
    always_comb begin
        st_nxt  = st;
        tm_load = 1'b0;
        tm_len  = '0;
        case (st)
            D_IDLE: begin
                if (hs_en && clk_hs) begin
                    st_nxt = D_LPX; tm_load = 1'b1; tm_len = len_lpx;
                end else if (!hs_en && ulp_en) begin
                    st_nxt = D_ULPS;
                end
            end
            D_LPX:   if (tm_done) begin st_nxt = D_PREP; tm_load = 1'b1; tm_len = len_prep; end
            D_PREP:  if (tm_done) begin st_nxt = D_ZERO; tm_load = 1'b1; tm_len = len_zero; end
            D_ZERO:  if (tm_done) st_nxt = D_ACT;
            D_ACT:   if (!hs_en) begin st_nxt = D_TRAIL; tm_load = 1'b1; tm_len = len_trail; end
            D_TRAIL: if (tm_done) begin st_nxt = D_EXIT; tm_load = 1'b1; tm_len = len_exit; end
            D_EXIT:  if (tm_done) st_nxt = D_IDLE;
            D_ULPS:  if (!ulp_en && wake) st_nxt = D_WAKE;
            D_WAKE:  if (!wake) begin st_nxt = D_EXIT; tm_load = 1'b1; tm_len = len_exit; end
            default: st_nxt = D_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= D_IDLE;
        else        st <= st_nxt;
    end

    // Line state decode.
    always_comb begin
        case (st)
            D_LPX:                    line = LN_LP01;
            D_PREP, D_ULPS, D_WAKE:   line = LN_LP00;
            D_ZERO, D_TRAIL:          line = LN_HS0;
            D_ACT:                    line = LN_HSACT;
            default:                  line = LN_LP11;
        endcase
    end

    assign ready = (st == D_ACT);
    assign busy  = (st == D_LPX) || (st == D_PREP) || (st == D_ZERO) ||
                   (st == D_ACT) || (st == D_TRAIL);
endmodule

// File: rtl/lane_seq_clk.sv
`timescale 1ns/1ps
// Clock-lane power-state FSM. Enters HS like the data lane, holds HS
// active while the data lane needs it, then runs post, trail and exit.
// Assumes hold is high while the data lane is mid-sequence or requesting.
module lane_seq_clk
    import lane_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_en,
    input  logic             ulp_en,
    input  logic             wake,
    input  logic             hold,
    input  logic [CNT_W-1:0] len_lpx,
    input  logic [CNT_W-1:0] len_prep,
    input  logic [CNT_W-1:0] len_zero,
    input  logic [CNT_W-1:0] len_post,
    input  logic [CNT_W-1:0] len_trail,
    input  logic [CNT_W-1:0] len_exit,
    output line_t            line,
    output logic             hs_on
);
    typedef enum logic [3:0] {
        C_IDLE, C_LPX, C_PREP, C_ZERO, C_ACT, C_POST, C_TRAIL, C_EXIT, C_ULPS, C_WAKE
    } cstate_t;

    cstate_t          st, st_nxt;
    logic             tm_load;
    logic [CNT_W-1:0] tm_len;
    logic             tm_done;

    lane_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tm_load),
        .len  (tm_len),
        .done (tm_done)
    );

    // Next state and phase-timer load for the clock lane.
    always_comb begin
        st_nxt  = st;
        tm_load = 1'b0;
        tm_len  = '0;
        case (st)
            C_IDLE: begin
                if (hs_en) begin
                    st_nxt = C_LPX; tm_load = 1'b1; tm_len = len_lpx;
                end else if (ulp_en) begin
                    st_nxt = C_ULPS;
                end
            end
            C_LPX:   if (tm_done) begin st_nxt = C_PREP; tm_load = 1'b1; tm_len = len_prep; end
            C_PREP:  if (tm_done) begin st_nxt = C_ZERO; tm_load = 1'b1; tm_len = len_zero; end
            C_ZERO:  if (tm_done) st_nxt = C_ACT;
            C_ACT:   if (!hs_en && !hold) begin st_nxt = C_POST; tm_load = 1'b1; tm_len = len_post; end
            C_POST:  if (tm_done) begin st_nxt = C_TRAIL; tm_load = 1'b1; tm_len = len_trail; end
            C_TRAIL: if (tm_done) begin st_nxt = C_EXIT; tm_load = 1'b1; tm_len = len_exit; end
            C_EXIT:  if (tm_done) st_nxt = C_IDLE;
            C_ULPS:  if (!ulp_en && wake) st_nxt = C_WAKE;
            C_WAKE:  if (!wake) begin st_nxt = C_EXIT; tm_load = 1'b1; tm_len = len_exit; end
            default: st_nxt = C_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nxt;
    end

    // Line state decode.
    always_comb begin
        case (st)
            C_LPX:                  line = LN_LP01;
            C_PREP, C_ULPS, C_WAKE: line = LN_LP00;
            C_ZERO, C_TRAIL:        line = LN_HS0;
            C_ACT, C_POST:          line = LN_HSACT;
            default:                line = LN_LP11;
        endcase
    end

    assign hs_on = (st == C_ACT);
endmodule

// File: rtl/lane_pwr_seq.sv
`timescale 1ns/1ps
// Top of the lane power-state sequencer: unpacks the four timing words
// into per-phase counts and couples the data-lane and clock-lane FSMs.
// Assumes timing words are stable while a lane is mid-sequence.
module lane_pwr_seq
    import lane_seq_pkg::*;
#(
    parameter int FIELD_W = FLD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4*FIELD_W-1:0] tw_data,
    input  logic [4*FIELD_W-1:0] tw_turn,
    input  logic [4*FIELD_W-1:0] tw_clk_a,
    input  logic [4*FIELD_W-1:0] tw_clk_b,
    input  logic [2:0]           dl_ctrl,
    input  logic [2:0]           cl_ctrl,
    output logic [2:0]           dl_line,
    output logic [2:0]           cl_line,
    output logic                 dl_ready
);
    localparam int NFLD = 4;

    logic [FIELD_W-1:0] f_data [NFLD];
    logic [FIELD_W-1:0] f_turn [NFLD];
    logic [FIELD_W-1:0] f_ca   [NFLD];
    logic [FIELD_W-1:0] f_cb   [NFLD];
    logic               unused_fields;
    logic               dl_busy, cl_hs_on, cl_hold;
    line_t              dl_code, cl_code;

    // Slice each timing word into its byte fields.
    for (genvar g = 0; g < NFLD; g++) begin : g_unpack
        assign f_data[g] = tw_data [g*FIELD_W +: FIELD_W];
        assign f_turn[g] = tw_turn [g*FIELD_W +: FIELD_W];
        assign f_ca[g]   = tw_clk_a[g*FIELD_W +: FIELD_W];
        assign f_cb[g]   = tw_clk_b[g*FIELD_W +: FIELD_W];
    end

    assign unused_fields = ^{f_turn[0], f_turn[1], f_turn[2],
                             f_ca[0], f_ca[1], f_cb[3]};

    assign cl_hold = dl_busy | dl_ctrl[CB_HS];

    lane_seq_data #(.CNT_W(FIELD_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (dl_ctrl[CB_HS]),
        .ulp_en   (dl_ctrl[CB_ULP]),
        .wake     (dl_ctrl[CB_WAKE]),
        .clk_hs   (cl_hs_on),
        .len_lpx  (f_data[0]),
        .len_prep (f_data[1]),
        .len_zero (f_data[2]),
        .len_trail(f_data[3]),
        .len_exit (f_turn[3]),
        .line     (dl_code),
        .ready    (dl_ready),
        .busy     (dl_busy)
    );

    lane_seq_clk #(.CNT_W(FIELD_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (cl_ctrl[CB_HS]),
        .ulp_en   (cl_ctrl[CB_ULP]),
        .wake     (cl_ctrl[CB_WAKE]),
        .hold     (cl_hold),
        .len_lpx  (f_data[0]),
        .len_prep (f_cb[0]),
        .len_zero (f_ca[2]),
        .len_post (f_cb[1]),
        .len_trail(f_ca[3]),
        .len_exit (f_cb[2]),
        .line     (cl_code),
        .hs_on    (cl_hs_on)
    );

    assign dl_line = dl_code;
    assign cl_line = cl_code;
endmodule

// File: rtl/lane_pwr_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the lane power-state sequencer, bound to the top.
// Assumes only port-level visibility of the two lanes.
module lane_pwr_seq_chk
    import lane_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] dl_ctrl,
    input logic [2:0] dl_line,
    input logic [2:0] cl_line,
    input logic       dl_ready
);
    // R3: data lane out of LP-11/LP-00 only while the clock lane is in HS
    p_clk_leads_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_line == LN_LP01 || dl_line == LN_HS0 || dl_line == LN_HSACT)
            |-> (cl_line == LN_HSACT));

    // R2: ready rises only out of the HS-0 zero phase
    p_ready_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_ready) |-> ($past(dl_line) == LN_HS0));

    // R2: LP-01 is followed by LP-01 or LP-00
    p_lp01_then_lp00_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_line == LN_LP01) |=> (dl_line == LN_LP01 || dl_line == LN_LP00));

    // R5: dropping the enable in HS active starts the trail next cycle
    p_trail_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_line == LN_HSACT && !dl_ctrl[CB_HS]) |=> (dl_line == LN_HS0));

    // R6: clock lane leaves HS active only through HS-0
    p_clk_hs_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_line == LN_HSACT) |=> (cl_line == LN_HSACT || cl_line == LN_HS0));
endmodule

bind lane_pwr_seq lane_pwr_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dl_ctrl (dl_ctrl),
    .dl_line (dl_line),
    .cl_line (cl_line),
    .dl_ready(dl_ready)
);

// File: tb/tb_lane_pwr_seq.sv
`timescale 1ns/1ps
module tb_lane_pwr_seq;
    localparam logic [2:0] LP11 = 3'd0, LP01 = 3'd1, LP00 = 3'd2, HS0 = 3'd3, HSA = 3'd4;
    localparam logic [2:0] NONE = 3'b000, HSEN = 3'b001, ULP = 3'b010, WAKE = 3'b100;

    typedef struct {
        logic [2:0] dl;
        logic [2:0] cl;
        logic       rdy;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tw_data, tw_turn, tw_clk_a, tw_clk_b;
    logic [2:0]  dl_ctrl = NONE, cl_ctrl = NONE;
    logic [2:0]  dl_line, cl_line;
    logic        dl_ready;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    exp_t        exp_q[$];
    exp_t        e;

    // Counts for the main timing set (data: lpx 2, prep 3, zero 1, trail 2, exit 3)
    // (clock: prep 2, zero 4, post 3, trail 2, exit 2); turnaround bytes are junk.
    localparam logic [31:0] TW_DATA  = {8'd2, 8'd1, 8'd3, 8'd2};
    localparam logic [31:0] TW_TURN  = {8'd3, 8'hA5, 8'h5A, 8'hC3};
    localparam logic [31:0] TW_CLK_A = {8'd2, 8'd4, 8'h99, 8'h81};
    localparam logic [31:0] TW_CLK_B = {8'hE7, 8'd2, 8'd3, 8'd2};

    always #2.5 clk = ~clk;

    lane_pwr_seq dut (
        .clk(clk), .rst_n(rst_n),
        .tw_data(tw_data), .tw_turn(tw_turn), .tw_clk_a(tw_clk_a), .tw_clk_b(tw_clk_b),
        .dl_ctrl(dl_ctrl), .cl_ctrl(cl_ctrl),
        .dl_line(dl_line), .cl_line(cl_line), .dl_ready(dl_ready)
    );

    // Driver: apply inputs for one cycle and queue the state expected after the edge.
    task automatic hold(input int n, input logic [2:0] d, input logic [2:0] c,
                        input logic [2:0] ed, input logic [2:0] ec, input logic er,
                        input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dl_ctrl = d;
            cl_ctrl = c;
            exp_q.push_back('{dl: ed, cl: ec, rdy: er, tag: tag});
        end
    endtask

    // Monitor: compare outputs against the scoreboard just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (dl_line !== e.dl || cl_line !== e.cl || dl_ready !== e.rdy) begin
                    errors++;
                    $display("FAIL %s: got dl=%0d cl=%0d rdy=%0d, expected dl=%0d cl=%0d rdy=%0d",
                             e.tag, dl_line, cl_line, dl_ready, e.dl, e.cl, e.rdy);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tw_data = TW_DATA; tw_turn = TW_TURN; tw_clk_a = TW_CLK_A; tw_clk_b = TW_CLK_B;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dl_line !== LP11 || cl_line !== LP11 || dl_ready !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got dl=%0d cl=%0d rdy=%0d, expected 0 0 0",
                     dl_line, cl_line, dl_ready);
        end
        rst_n = 1'b1;

        // R1 idle after reset; R3 data waits for the clock lane
        hold(2, NONE, NONE, LP11, LP11, 0, "R1 idle");
        hold(3, HSEN, NONE, LP11, LP11, 0, "R3 wait for clock");
        // R4 clock entry, R8 field positions
        hold(2, HSEN, HSEN, LP11, LP01, 0, "R4 clock LP-01");
        hold(2, HSEN, HSEN, LP11, LP00, 0, "R4 clock prepare");
        hold(4, HSEN, HSEN, LP11, HS0,  0, "R4 clock zero");
        hold(1, HSEN, HSEN, LP11, HSA,  0, "R3 one cycle after clock HS");
        // R2 data entry
        hold(2, HSEN, HSEN, LP01, HSA, 0, "R2 data LP-01");
        hold(3, HSEN, HSEN, LP00, HSA, 0, "R2 data prepare");
        hold(1, HSEN, HSEN, HS0,  HSA, 0, "R2 data zero");
        hold(3, HSEN, HSEN, HSA,  HSA, 1, "R2 data ready");
        // R5 exit: request during the LP-11 hold is ignored
        hold(2, NONE, HSEN, HS0,  HSA, 0, "R5 trail");
        hold(3, HSEN, HSEN, LP11, HSA, 0, "R5 exit hold ignores request");
        hold(1, HSEN, HSEN, LP11, HSA, 0, "R5 idle cycle");
        hold(2, HSEN, HSEN, LP01, HSA, 0, "R5 re-entry LP-01");
        hold(3, HSEN, HSEN, LP00, HSA, 0, "R5 re-entry prepare");
        hold(1, HSEN, HSEN, HS0,  HSA, 0, "R5 re-entry zero");
        hold(2, HSEN, HSEN, HSA,  HSA, 1, "R5 re-entry ready");
        // R6 joint shutdown: clock held through data trail, then post/trail/exit
        hold(2, NONE, NONE, HS0,  HSA,  0, "R6 clock held in data trail");
        hold(4, NONE, NONE, LP11, HSA,  0, "R6 clock post");
        hold(2, NONE, NONE, LP11, HS0,  0, "R6 clock trail");
        hold(2, NONE, NONE, LP11, LP11, 0, "R6 clock exit");
        hold(2, NONE, NONE, LP11, LP11, 0, "R6 idle");

        // R7 all counts zero -> one cycle per phase
        @(negedge clk);
        tw_data = '0; tw_turn = '0; tw_clk_a = '0; tw_clk_b = '0;
        hold(1, HSEN, HSEN, LP11, LP01, 0, "R7 clock LP-01");
        hold(1, HSEN, HSEN, LP11, LP00, 0, "R7 clock prepare");
        hold(1, HSEN, HSEN, LP11, HS0,  0, "R7 clock zero");
        hold(1, HSEN, HSEN, LP11, HSA,  0, "R7 clock HS");
        hold(1, HSEN, HSEN, LP01, HSA,  0, "R7 data LP-01");
        hold(1, HSEN, HSEN, LP00, HSA,  0, "R7 data prepare");
        hold(1, HSEN, HSEN, HS0,  HSA,  0, "R7 data zero");
        hold(2, HSEN, HSEN, HSA,  HSA,  1, "R7 data ready");
        hold(1, NONE, NONE, HS0,  HSA,  0, "R7 data trail");
        hold(1, NONE, NONE, LP11, HSA,  0, "R7 data exit, clock held");
        hold(1, NONE, NONE, LP11, HSA,  0, "R7 clock post");
        hold(1, NONE, NONE, LP11, HS0,  0, "R7 clock trail");
        hold(2, NONE, NONE, LP11, LP11, 0, "R7 clock exit then idle");
        @(negedge clk);
        tw_data = TW_DATA; tw_turn = TW_TURN; tw_clk_a = TW_CLK_A; tw_clk_b = TW_CLK_B;

        // R9 ultra-low-power entry, HS request ignored
        hold(2, ULP,         NONE, LP00, LP11, 0, "R9 data enters ULP");
        hold(2, ULP | HSEN,  NONE, LP00, LP11, 0, "R9 HS request ignored in ULP");
        // R10 wake while ULP still enabled has no effect
        hold(2, ULP | WAKE,  NONE, LP00, LP11, 0, "R10 wake with ULP set");
        hold(2, ULP,         NONE, LP00, LP11, 0, "R10 still in ULP after ignored pulse");
        hold(1, WAKE,        NONE, LP00, LP11, 0, "R10 wake high");
        hold(3, NONE,        NONE, LP11, LP11, 0, "R10 exit hold after wake");
        hold(1, NONE,        NONE, LP11, LP11, 0, "R10 data idle");
        // R9/R10 on the clock lane
        hold(1, NONE, ULP,  LP11, LP00, 0, "R9 clock enters ULP");
        hold(1, NONE, WAKE, LP11, LP00, 0, "R10 clock wake high");
        hold(2, NONE, NONE, LP11, LP11, 0, "R10 clock exit hold");
        hold(1, NONE, NONE, LP11, LP11, 0, "R10 clock idle");

        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule